// File: doc/BRIEF.md
# Receive Character Buffer with Lockstep Error Flags

This block sits between a serial receiver and the CPU. Each assembled character arrives on a write strobe with its framing-error and parity-error flags. The character goes into a data FIFO. Its two flags go into a separate flag FIFO of the same depth, and both FIFOs share the same pointers. A flag therefore always leaves the buffer together with the character it was reported with.

The read side shows the head character and its status. The framing status is not latched: it reflects only the entry at the head. The parity status is held from the moment a flagged character is popped until the CPU issues an error-reset. Overrun also holds until error-reset. It is raised when a character arrives while every slot is occupied and nothing is read in that cycle. The new character then replaces the most recently stored one.

A special-condition request combines these conditions for interrupt logic. Because a read pops the flag entry together with the data, software must sample the status before it reads the byte.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the buffer is empty (`fifo_empty`=1, `fifo_full`=0, `char_avail`=0), and `frame_err`, `parity_err`, `overrun_err` and `special_irq` are all 0.
- R2: Characters are read out in the order they were written. `rd_data` shows the head character whenever `char_avail` is 1, and a `rd_en` pulse removes it.
- R3: The `frame_err` and `parity_err` flags written with a character are the ones shown while that character is at the head.
- R4: `frame_err` is not latched. It is 1 only while the head character carries a framing flag, and it drops when that character is read and a clean character becomes the head.
- R5: `parity_err` is 1 while the head character carries a parity flag. Once such a character has been read, the flag stays 1 until `err_reset` is pulsed. An `err_reset` issued while the flagged character is still at the head does not hide it.
- R6: A write while the buffer holds DEPTH characters and no read happens in the same cycle sets `overrun_err`. The occupancy stays at DEPTH, and the incoming character replaces the most recently stored one. `overrun_err` stays 1 until `err_reset`.
- R7: With a full buffer, a write and a read in the same cycle both take effect and do not set `overrun_err`.
- R8: A `rd_en` pulse while the buffer is empty has no effect.
- R9: `special_irq` is 1 whenever `frame_err` or `overrun_err` is 1, or when `parity_err` is 1 and `parity_irq_en` is 1. Otherwise it is 0.
- R10: `fifo_full` is 1 exactly when DEPTH characters are stored, and `fifo_empty` is 1 exactly when none are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver delivers a character this cycle |
| wr_data | input | DATA_W | Received character |
| wr_frame_err | input | 1 | Stop bit of this character was 0 |
| wr_parity_err | input | 1 | Parity check failed for this character |
| rd_en | input | 1 | CPU reads (pops) the head character |
| err_reset | input | 1 | Clears the held parity and overrun status |
| parity_irq_en | input | 1 | Lets parity errors raise `special_irq` |
| rd_data | output | DATA_W | Head character |
| char_avail | output | 1 | At least one character is stored |
| fifo_empty | output | 1 | No character stored |
| fifo_full | output | 1 | DEPTH characters stored |
| frame_err | output | 1 | Framing flag of the head entry |
| parity_err | output | 1 | Parity status, held after the read |
| overrun_err | output | 1 | Held overrun status |
| special_irq | output | 1 | Special-condition request |

## Verification
The bench first sends clean runs of characters. These show ordering and pointer wrap apart from any flag handling. Next, a framing-flagged character is followed by a clean one, which separates the unlatched framing status from a held one. A parity-flagged character is read with the interrupt enable off and then on, and an error-reset is issued both before and after its read. This shows that the held parity status and its gating are separate from the head-only term. Finally, the buffer is filled and written once more, with and without a concurrent read. This distinguishes a true overrun, which replaces the newest character, from a full-buffer pass-through. A read of an empty buffer shows that the pointers do not move.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef struct packed {
      logic frame;
      logic parity;
   } rx_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  rxf_pkg::rx_flags_t  wr_flags,
   input  logic                rd_en,
   output logic [DATA_W-1:0]   head_data,
   output rxf_pkg::rx_flags_t  head_flags,
   output logic                empty,
   output logic                full,
   output logic                pop,
   output logic                ovr_evt
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [DATA_W-1:0]  data_mem [DEPTH];
   rxf_pkg::rx_flags_t flag_mem [DEPTH];

   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt, wr_last;
   logic [CW-1:0] count;
   logic          push;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt  = wr_ptr + 1'b1;
         assign rd_nxt  = rd_ptr + 1'b1;
         assign wr_last = wr_ptr - 1'b1;
      end else begin : g_mod
         assign wr_nxt  = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt  = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_last = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign pop     = rd_en & ~empty;
   assign push    = wr_en & (~full | pop);
   assign ovr_evt = wr_en & full & ~pop;

   assign head_data  = data_mem[rd_ptr];
   assign head_flags = flag_mem[rd_ptr];

   // data FIFO and flag FIFO share addresses, so flags move with their character
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            data_mem[i] <= '0;
            flag_mem[i] <= '0;
         end
      end else if (push) begin
         data_mem[wr_ptr] <= wr_data;
         flag_mem[wr_ptr] <= wr_flags;
      end else if (ovr_evt) begin
         data_mem[wr_last] <= wr_data;
         flag_mem[wr_last] <= wr_flags;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/rxf_status.sv
module rxf_status (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               head_valid,
   input  rxf_pkg::rx_flags_t head_flags,
   input  logic               pop,
   input  logic               ovr_evt,
   input  logic               err_reset,
   input  logic               parity_irq_en,
   output logic               frame_err,
   output logic               parity_err,
   output logic               overrun_err,
   output logic               special_irq
);
   logic par_q, ovr_q;

   // a new event in the same cycle as err_reset wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (pop && head_flags.parity) par_q <= 1'b1;
         else if (err_reset)           par_q <= 1'b0;
         if (ovr_evt)                  ovr_q <= 1'b1;
         else if (err_reset)           ovr_q <= 1'b0;
      end
   end

   assign frame_err   = head_valid & head_flags.frame;
   assign parity_err  = par_q | (head_valid & head_flags.parity);
   assign overrun_err = ovr_q;
   assign special_irq = frame_err | ovr_q | (parity_irq_en & parity_err);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_frame_err,
   input  logic              wr_parity_err,
   input  logic              rd_en,
   input  logic              err_reset,
   input  logic              parity_irq_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              char_avail,
   output logic              fifo_empty,
   output logic              fifo_full,
   output logic              frame_err,
   output logic              parity_err,
   output logic              overrun_err,
   output logic              special_irq
);
   generate
      if (DEPTH < 2)  begin : g_bad_depth  $error("DEPTH must be at least 2");  end
      if (DATA_W < 1) begin : g_bad_width  $error("DATA_W must be at least 1"); end
   endgenerate

   rxf_pkg::rx_flags_t in_flags, head_flags;
   logic pop, ovr_evt;

   assign in_flags.frame  = wr_frame_err;
   assign in_flags.parity = wr_parity_err;

   rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .wr_flags   (in_flags),
      .rd_en      (rd_en),
      .head_data  (rd_data),
      .head_flags (head_flags),
      .empty      (fifo_empty),
      .full       (fifo_full),
      .pop        (pop),
      .ovr_evt    (ovr_evt)
   );

   assign char_avail = ~fifo_empty;

   rxf_status u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .head_valid    (char_avail),
      .head_flags    (head_flags),
      .pop           (pop),
      .ovr_evt       (ovr_evt),
      .err_reset     (err_reset),
      .parity_irq_en (parity_irq_en),
      .frame_err     (frame_err),
      .parity_err    (parity_err),
      .overrun_err   (overrun_err),
      .special_irq   (special_irq)
   );
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic rd_en,
   input logic err_reset,
   input logic char_avail,
   input logic fifo_empty,
   input logic fifo_full,
   input logic frame_err,
   input logic parity_err,
   input logic overrun_err,
   input logic special_irq
);
   a_r10_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));

   a_r8_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !wr_en && rd_en) |=> fifo_empty);

   a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fifo_full && !rd_en) |=> (overrun_err && fifo_full));

   a_r6_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_err && !err_reset) |=> overrun_err);

   a_r7_full_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && fifo_full && !overrun_err) |=> (fifo_full && !overrun_err));

   a_r5_parity_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (parity_err && !err_reset) |=> parity_err);

   a_r4_frame_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> char_avail);

   a_r9_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err || overrun_err) |-> special_irq);
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .err_reset   (err_reset),
   .char_avail  (char_avail),
   .fifo_empty  (fifo_empty),
   .fifo_full   (fifo_full),
   .frame_err   (frame_err),
   .parity_err  (parity_err),
   .overrun_err (overrun_err),
   .special_irq (special_irq)
);

// File: tb/rx_err_fifo_tb.sv
`timescale 1ns/1ps
module rx_err_fifo_tb;
   localparam int DW = 8;
   localparam int DP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_fe = 1'b0, wr_pe = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic rd_en = 1'b0, err_reset = 1'b0, par_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic char_avail, fifo_empty, fifo_full, frame_err, parity_err, overrun_err, special_irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_err_fifo #(.DATA_W(DW), .DEPTH(DP)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_frame_err(wr_fe), .wr_parity_err(wr_pe), .rd_en(rd_en),
      .err_reset(err_reset), .parity_irq_en(par_en), .rd_data(rd_data),
      .char_avail(char_avail), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .frame_err(frame_err), .parity_err(parity_err), .overrun_err(overrun_err),
      .special_irq(special_irq)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(logic [DW-1:0] d, logic fe, logic pe);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; wr_fe = fe; wr_pe = pe;
      @(negedge clk);
      wr_en = 1'b0; wr_fe = 1'b0; wr_pe = 1'b0;
   endtask

   task automatic pop_expect(string req, logic [DW-1:0] d);
      chk(req, "char_avail", char_avail, 1);
      chk(req, "rd_data", rd_data, d);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ereset();
      @(negedge clk);
      err_reset = 1'b1;
      @(negedge clk);
      err_reset = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "empty", fifo_empty, 1);
      chk("R1", "full", fifo_full, 0);
      chk("R1", "avail", char_avail, 0);
      chk("R1", "errs", {frame_err, parity_err, overrun_err}, 0);
      chk("R1", "irq", special_irq, 0);
   endtask

   task automatic t_order();
      push(8'hA1, 0, 0); push(8'hB2, 0, 0); push(8'hC3, 0, 0);
      pop_expect("R2", 8'hA1);
      pop_expect("R2", 8'hB2);
      pop_expect("R2", 8'hC3);
      chk("R10", "empty after drain", fifo_empty, 1);
   endtask

   task automatic t_frame();
      push(8'h11, 1, 0); push(8'h22, 0, 0);
      chk("R3", "frame with head", frame_err, 1);
      chk("R3", "parity with head", parity_err, 0);
      chk("R9", "irq on frame", special_irq, 1);
      pop_expect("R3", 8'h11);
      chk("R4", "frame drops", frame_err, 0);
      chk("R9", "irq after frame", special_irq, 0);
      pop_expect("R4", 8'h22);
   endtask

   task automatic t_parity();
      par_en = 1'b0;
      push(8'h33, 0, 1); push(8'h44, 0, 0);
      chk("R3", "parity with head", parity_err, 1);
      chk("R9", "parity masked", special_irq, 0);
      par_en = 1'b1; #0.1;
      chk("R9", "parity enabled", special_irq, 1);
      ereset();
      chk("R5", "reset at head keeps", parity_err, 1);
      pop_expect("R5", 8'h33);
      chk("R5", "held after read", parity_err, 1);
      chk("R4", "no frame", frame_err, 0);
      pop_expect("R5", 8'h44);
      chk("R5", "held when empty", parity_err, 1);
      ereset();
      chk("R5", "cleared", parity_err, 0);
      chk("R9", "irq cleared", special_irq, 0);
      par_en = 1'b0;
   endtask

   task automatic t_overrun();
      for (int i = 0; i < DP; i++) push(8'h50 + 8'(i), 0, 0);
      chk("R10", "full", fifo_full, 1);
      chk("R6", "no overrun yet", overrun_err, 0);
      push(8'hEE, 0, 0);
      chk("R6", "overrun set", overrun_err, 1);
      chk("R6", "still full", fifo_full, 1);
      chk("R9", "irq on overrun", special_irq, 1);
      for (int i = 0; i < DP - 1; i++) pop_expect("R6", 8'h50 + 8'(i));
      pop_expect("R6", 8'hEE);
      chk("R6", "empty after drain", fifo_empty, 1);
      chk("R6", "overrun held", overrun_err, 1);
      ereset();
      chk("R6", "overrun cleared", overrun_err, 0);
   endtask

   task automatic t_concurrent();
      for (int i = 0; i < DP; i++) push(8'h60 + 8'(i), 0, 0);
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h77;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R7", "no overrun", overrun_err, 0);
      chk("R7", "full kept", fifo_full, 1);
      for (int i = 1; i < DP; i++) pop_expect("R7", 8'h60 + 8'(i));
      pop_expect("R7", 8'h77);
      chk("R7", "empty", fifo_empty, 1);
   endtask

   task automatic t_empty_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk("R8", "still empty", fifo_empty, 1);
      chk("R8", "not full", fifo_full, 0);
      push(8'h99, 0, 0);
      pop_expect("R8", 8'h99);
      chk("R8", "single entry", fifo_empty, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_frame();
      t_parity();
      t_overrun();
      t_concurrent();
      t_empty_read();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule